// File: doc/BRIEF.md
# Multi-Mode Counter Clock Decoder

This block sits in front of a counter core and turns two external phase inputs, A and B, plus a free-running internal tick into a single-cycle count strobe and a direction bit. A 3-bit mode input selects how the inputs are read. Four modes decode A and B as a two-phase quadrature pair at x1, x2 or x4 resolution. Three modes use A alone as a single-phase clock and take the direction from the level of B. The last mode counts the internal tick while A acts as a gate.

Both external phases are resynchronised to the system clock before any edges are detected. Each qualifying edge yields exactly one count strobe. In x4 mode, a transition where both phases move in the same sample is rejected and flagged. The counter core downstream adds one on a strobe with the direction bit high and subtracts one on a strobe with the direction bit low.

Top module: `ccd_top`

## Requirements
- R1: After the synchronous active-low reset is released, `cnt_pulse_o`, `cnt_up_o` and `err_o` stay low for the first SYNC_STAGES+1 clock edges. During that time the synchroniser and the stored previous samples fill with real input values, so a phase that is already high at reset release is never taken as an edge.
- R2: A change on a phase input that is first sampled at clock edge k raises `cnt_pulse_o` after edge k+SYNC_STAGES for exactly one cycle, provided the change qualifies in the active mode. With the default SYNC_STAGES=2, the strobe appears after edge k+2 and is low again after edge k+3.
- R3: Mode value 0 strobes only on a rising edge of A. Mode value 1 strobes only on a falling edge of A. Edges of B produce nothing in either mode, so one full quadrature cycle gives one strobe.
- R4: Mode value 2 strobes on both edges of A and ignores edges of B, giving two strobes per quadrature cycle.
- R5: Mode value 3 strobes on every single-phase change of A or B, giving four strobes per quadrature cycle.
- R6: In modes 0 to 3, direction follows the phase relation. On an A edge, `cnt_up_o` is 1 when the new A differs from B. On a B edge, `cnt_up_o` is 1 when the new B equals A. As a result, the sequence AB = 00,10,11,01 counts up and its reverse counts down.
- R7: In mode 3, a sample where A and B both change gives no strobe and raises `err_o` for one cycle. `err_o` is never raised in any other mode.
- R8: Modes 4, 5 and 6 strobe on the rising edge of A, the falling edge of A and both edges of A respectively. In these modes `cnt_up_o` equals the synchronised level of B.
- R9: Mode 7 strobes in each cycle where `tick_i` is high while the synchronised A is high, with `cnt_up_o` equal to the synchronised B. When the synchronised A is low, no tick is counted.
- R10: When `mode_i` differs from the registered mode, decoding is suppressed in the cycle in which the new mode is taken. The next output therefore carries no strobe, whatever the phases did.
- R11: `cnt_up_o` is low in every cycle where `cnt_pulse_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 3 | Clocking mode selector (0 to 7) |
| phase_a_i | input | 1 | External phase A (asynchronous) |
| phase_b_i | input | 1 | External phase B (asynchronous) |
| tick_i | input | 1 | Internal count tick, one clock wide, synchronous |
| cnt_pulse_o | output | 1 | One-cycle count strobe |
| cnt_up_o | output | 1 | Direction for the strobe: 1 up, 0 down |
| err_o | output | 1 | One-cycle flag for an illegal x4 transition |

## Verification
Quadrature sequences are run forwards and in reverse in each of modes 0 to 3. The strobe totals separate x1, x2 and x4 behaviour, and the direction totals show whether the phase-relation rule is right. Single-phase runs with B held at each level confirm that the direction comes from the level of B rather than from phase order. A simultaneous change of both phases is tried in mode 3 and in a non-x4 mode, which checks that the error flag appears only where it belongs. Further tests cover the internal tick with the gate open and closed, a mode switch timed to land on a pending edge, and a single isolated edge used to pin down the latency.

// File: rtl/ccd_pkg.sv
// Package: shared mode encoding and decode result type for the counter
// clock decoder. Assumes the mode field is three bits wide.
package ccd_pkg;

    typedef enum logic [2:0] {
        MODE_QX1_RISE = 3'd0,
        MODE_QX1_FALL = 3'd1,
        MODE_QX2      = 3'd2,
        MODE_QX4      = 3'd3,
        MODE_SP_RISE  = 3'd4,
        MODE_SP_FALL  = 3'd5,
        MODE_SP_BOTH  = 3'd6,
        MODE_GATED    = 3'd7
    } clk_mode_e;

    typedef struct packed {
        logic pulse;
        logic up;
        logic err;
    } dec_out_t;

endpackage

// File: rtl/ccd_sync.sv
// Module: multi-bit, multi-stage flip-flop synchroniser. Each bit gets its
// own shift chain. Assumes STAGES >= 2 and that the inputs are independent
// levels; no cross-bit coherence is promised.
module ccd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the asynchronous bit through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
        end

        assign q_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/ccd_decode.sv
// Module: purely combinational edge classifier. It compares the current
// synchronised phases with the previous samples and returns strobe,
// direction and error for the selected mode. Assumes all inputs are
// already in the clock domain; enable_i low forces an idle result.
module ccd_decode
    import ccd_pkg::*;
(
    input  clk_mode_e mode_i,
    input  logic      enable_i,
    input  logic      a_now_i,
    input  logic      b_now_i,
    input  logic      a_prev_i,
    input  logic      b_prev_i,
    input  logic      tick_i,
    output dec_out_t  dec_o
);

    logic a_rise, a_fall, a_chg, b_chg;
    logic up_on_a, up_on_b;
    dec_out_t raw;

    assign a_rise  = a_now_i & ~a_prev_i;
    assign a_fall  = ~a_now_i & a_prev_i;
    assign a_chg   = a_now_i ^ a_prev_i;
    assign b_chg   = b_now_i ^ b_prev_i;
    // A leading B means counting up: A edges agree with up when A != B after
    // the edge, B edges agree with up when B == A after the edge.
    assign up_on_a = a_now_i ^ b_now_i;
    assign up_on_b = ~(a_now_i ^ b_now_i);

    // Classify the current sample according to the active mode.
    always_comb begin
        raw = '0;
        unique case (mode_i)
            MODE_QX1_RISE: begin raw.pulse = a_rise; raw.up = up_on_a; end
            MODE_QX1_FALL: begin raw.pulse = a_fall; raw.up = up_on_a; end
            MODE_QX2:      begin raw.pulse = a_chg;  raw.up = up_on_a; end
            MODE_QX4: begin
                if (a_chg && b_chg) begin
                    raw.err = 1'b1;
                end else if (a_chg) begin
                    raw.pulse = 1'b1;
                    raw.up    = up_on_a;
                end else if (b_chg) begin
                    raw.pulse = 1'b1;
                    raw.up    = up_on_b;
                end
            end
            MODE_SP_RISE:  begin raw.pulse = a_rise;  raw.up = b_now_i; end
            MODE_SP_FALL:  begin raw.pulse = a_fall;  raw.up = b_now_i; end
            MODE_SP_BOTH:  begin raw.pulse = a_chg;   raw.up = b_now_i; end
            MODE_GATED:    begin raw.pulse = tick_i & a_now_i; raw.up = b_now_i; end
            default:       raw = '0;
        endcase
    end

    // Gate the result and keep direction quiet when there is no strobe.
    always_comb begin
        dec_o.pulse = enable_i & raw.pulse;
        dec_o.up    = enable_i & raw.pulse & raw.up;
        dec_o.err   = enable_i & raw.err;
    end

endmodule

// File: rtl/ccd_top.sv
// Module: counter clock decoder top. It synchronises phases A and B,
// registers the mode, holds the previous samples and registers the
// decoded strobe, direction and error. It assumes tick_i is synchronous to
// clk and at most one cycle wide per tick. After reset, decoding stays
// disarmed until the synchroniser has filled. A mode change suppresses the
// decode in the cycle in which the new mode is taken.
module ccd_top
    import ccd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       phase_a_i,
    input  logic       phase_b_i,
    input  logic       tick_i,
    output logic       cnt_pulse_o,
    output logic       cnt_up_o,
    output logic       err_o
);

    localparam int ARM_INIT = SYNC_STAGES + 1;
    localparam int ARM_W    = $clog2(ARM_INIT + 1);

    logic [1:0]       sync_ab;
    logic [1:0]       prev_q;
    logic [2:0]       mode_q;
    logic [ARM_W-1:0] arm_q;
    logic             mode_chg;
    logic             dec_en;
    dec_out_t         dec;

    ccd_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({phase_b_i, phase_a_i}),
        .q_o   (sync_ab)
    );

    assign mode_chg = (mode_i != mode_q);
    assign dec_en   = (arm_q == '0) && !mode_chg;

    // Register the mode and the previous phase samples; count down arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            prev_q <= '0;
            arm_q  <= ARM_W'(ARM_INIT);
        end else begin
            mode_q <= mode_i;
            prev_q <= sync_ab;
            if (arm_q != '0) arm_q <= arm_q - 1'b1;
        end
    end

    ccd_decode dec_i (
        .mode_i   (clk_mode_e'(mode_q)),
        .enable_i (dec_en),
        .a_now_i  (sync_ab[0]),
        .b_now_i  (sync_ab[1]),
        .a_prev_i (prev_q[0]),
        .b_prev_i (prev_q[1]),
        .tick_i   (tick_i),
        .dec_o    (dec)
    );

    // Register the decoded outputs so each strobe is a clean single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_pulse_o <= 1'b0;
            cnt_up_o    <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            cnt_pulse_o <= dec.pulse;
            cnt_up_o    <= dec.up;
            err_o       <= dec.err;
        end
    end

endmodule

// File: rtl/ccd_checker.sv
// Module: property checker for ccd_top, attached by bind. It keeps its own
// record of the mode input and of the cycles since reset, and relates them
// to the registered outputs.
module ccd_checker #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_i,
    input logic       tick_i,
    input logic       cnt_pulse_o,
    input logic       cnt_up_o,
    input logic       err_o
);

    localparam int QUIET = SYNC_STAGES + 1;
    localparam int CNT_W = $clog2(QUIET + 2) + 1;

    logic [2:0]       mode_seen;
    logic [CNT_W-1:0] since_rst;

    // Track the previous mode input and a saturating count since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_seen <= '0;
            since_rst <= '0;
        end else begin
            mode_seen <= mode_i;
            if (since_rst != '1) since_rst <= since_rst + 1'b1;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(since_rst) <= QUIET) |-> !cnt_pulse_o);

    a_r7_err_only_x4: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(mode_seen) == 3'd3));

    a_r7_err_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !cnt_pulse_o);

    a_r9_gated_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pulse_o && ($past(mode_seen) == 3'd7)) |-> $past(tick_i));

    a_r10_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != mode_seen) |=> !cnt_pulse_o);

    a_r11_up_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_up_o |-> cnt_pulse_o);

endmodule

bind ccd_top ccd_checker #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .tick_i      (tick_i),
    .cnt_pulse_o (cnt_pulse_o),
    .cnt_up_o    (cnt_up_o),
    .err_o       (err_o)
);

// File: tb/ccd_top_tb_top.sv
// Bench: behavioural reference model compared every cycle, plus directed
// tally and latency checks.
module ccd_top_tb_top;

    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       pa = 1'b0;
    logic       pb = 1'b0;
    logic       tick = 1'b0;
    logic       pulse, up, err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit tick_en = 0;
    int tick_div = 0;

    // reference model state
    int qa[$];
    int qb[$];
    int prev_a, prev_b, arm, mode_m;
    int exp_p, exp_u, exp_e;
    string exp_tag;
    bit cmp_on = 0;

    int n_pulse, n_up, n_err;
    int cur_idx = 0;

    always #10 clk = ~clk;

    ccd_top #(.SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .phase_a_i(pa), .phase_b_i(pb), .tick_i(tick),
        .cnt_pulse_o(pulse), .cnt_up_o(up), .err_o(err)
    );

    function automatic string tag_of(int m);
        if (m <= 1) return "R3";
        if (m == 2) return "R4";
        if (m == 3) return "R5";
        if (m <= 6) return "R8";
        return "R9";
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            qa = {}; qb = {};
            for (int i = 0; i < SYNC; i++) begin qa.push_back(0); qb.push_back(0); end
            prev_a = 0; prev_b = 0; arm = SYNC + 1; mode_m = 0;
            exp_p = 0; exp_u = 0; exp_e = 0; exp_tag = "R1";
        end else begin
            int a2, b2, ac, bc, en;
            a2 = qa[SYNC-1]; b2 = qb[SYNC-1];
            ac = (a2 != prev_a); bc = (b2 != prev_b);
            en = (arm == 0) && (int'(mode) == mode_m);
            exp_p = 0; exp_u = 0; exp_e = 0;
            exp_tag = (arm != 0) ? "R1" : (!en ? "R10" : tag_of(mode_m));
            if (en) begin
                case (mode_m)
                    0: begin exp_p = (a2 == 1 && prev_a == 0); exp_u = (a2 != b2); end
                    1: begin exp_p = (a2 == 0 && prev_a == 1); exp_u = (a2 != b2); end
                    2: begin exp_p = ac; exp_u = (a2 != b2); end
                    3: begin
                        if (ac && bc) exp_e = 1;
                        else if (ac) begin exp_p = 1; exp_u = (a2 != b2); end
                        else if (bc) begin exp_p = 1; exp_u = (a2 == b2); end
                    end
                    4: begin exp_p = (a2 == 1 && prev_a == 0); exp_u = b2; end
                    5: begin exp_p = (a2 == 0 && prev_a == 1); exp_u = b2; end
                    6: begin exp_p = ac; exp_u = b2; end
                    default: begin exp_p = (tick && a2); exp_u = b2; end
                endcase
                if (!exp_p) exp_u = 0;
            end
            prev_a = a2; prev_b = b2;
            qa.push_front(int'(pa)); void'(qa.pop_back());
            qb.push_front(int'(pb)); void'(qb.pop_back());
            mode_m = int'(mode);
            if (arm > 0) arm--;
        end
    end

    // Compare and tally on every falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (pulse !== exp_p[0] || err !== exp_e[0]) begin
                errors++;
                $display("FAIL %s: pulse/err %b/%b expected %0d/%0d at %0t",
                         (exp_e || err) ? "R7" : exp_tag, pulse, err, exp_p, exp_e, $time);
            end else if (up !== exp_u[0]) begin
                errors++;
                $display("FAIL %s: up %b expected %0d at %0t",
                         (!exp_p) ? "R11" : ((mode_m <= 3) ? "R6" : exp_tag), up, exp_u, $time);
            end
            n_pulse += int'(pulse); n_up += int'(up); n_err += int'(err);
        end
        if (tick_en) begin
            tick_div = (tick_div + 1) % 5;
            tick = (tick_div == 0);
        end else tick = 1'b0;
    end

    task automatic chk(input string req, input int act, input int exp_v, input string what);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_tally();
        n_pulse = 0; n_up = 0; n_err = 0;
    endtask

    task automatic set_idx(input int idx);
        cur_idx = idx;
        pa = (idx == 1 || idx == 2);
        pb = (idx == 2 || idx == 3);
    endtask

    // Walk the quadrature states; forward gives AB 00,10,11,01.
    task automatic quad_run(input bit fwd, input int steps, input int gap);
        for (int s = 0; s < steps; s++) begin
            @(negedge clk);
            set_idx(fwd ? (cur_idx + 1) % 4 : (cur_idx + 3) % 4);
            idle(gap);
        end
        idle(5);
    endtask

    task automatic use_mode(input int m);
        @(negedge clk); mode = 3'(m); idle(5); clr_tally();
    endtask

    task automatic toggle_a(input int n);
        for (int s = 0; s < n; s++) begin
            @(negedge clk); pa = ~pa; idle(2);
        end
        idle(5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet in reset and while arming, phases held high
        pa = 1'b1; pb = 1'b1; mode = 3'd6;
        idle(3);
        chk("R1", int'(pulse) + int'(up) + int'(err), 0, "outputs in reset");
        cmp_on = 1;
        clr_tally();
        @(negedge clk); rst_n = 1'b1;
        idle(8);
        chk("R1", n_pulse + n_err, 0, "strobes with inputs high at release");
        pa = 1'b0; pb = 1'b0; idle(6);

        // R2: latency of a single rising edge in mode 6 (already selected)
        @(negedge clk); pa = 1'b1;
        @(negedge clk); chk("R2", int'(pulse), 0, "strobe after first edge");
        @(negedge clk); chk("R2", int'(pulse), 0, "strobe after second edge");
        @(negedge clk); chk("R2", int'(pulse), 1, "strobe after third edge");
        @(negedge clk); chk("R2", int'(pulse), 0, "strobe width");
        @(negedge clk); pa = 1'b0; idle(5);
        set_idx(0);

        // R3: x1 on rising and falling A; R6 direction
        use_mode(0); quad_run(1, 12, 2);
        chk("R3", n_pulse, 3, "mode 0 forward strobes");
        chk("R6", n_up, 3, "mode 0 forward ups");
        use_mode(1); quad_run(0, 12, 2);
        chk("R3", n_pulse, 3, "mode 1 reverse strobes");
        chk("R6", n_up, 0, "mode 1 reverse ups");

        // R4: x2
        use_mode(2); quad_run(1, 16, 1);
        chk("R4", n_pulse, 8, "mode 2 forward strobes");
        chk("R6", n_up, 8, "mode 2 forward ups");

        // R5: x4, back-to-back changes
        use_mode(3); quad_run(1, 16, 0);
        chk("R5", n_pulse, 16, "mode 3 forward strobes");
        chk("R6", n_up, 16, "mode 3 forward ups");
        clr_tally(); quad_run(0, 12, 1);
        chk("R5", n_pulse, 12, "mode 3 reverse strobes");
        chk("R6", n_up, 0, "mode 3 reverse ups");

        // R7: simultaneous change in x4, then in a non-x4 mode
        set_idx(0); idle(5); clr_tally();
        @(negedge clk); pa = 1'b1; pb = 1'b1; idle(6);
        chk("R7", n_err, 1, "x4 illegal error flags");
        chk("R7", n_pulse, 0, "x4 illegal strobes");
        use_mode(2);
        @(negedge clk); pa = 1'b0; pb = 1'b0; idle(6);
        chk("R7", n_err, 0, "error flags outside x4");
        set_idx(0);

        // R8: single-phase, direction from B level
        use_mode(4); pb = 1'b1; idle(4); clr_tally(); toggle_a(6);
        chk("R8", n_pulse, 3, "mode 4 strobes");
        chk("R8", n_up, 3, "mode 4 ups with B high");
        use_mode(5); pb = 1'b0; idle(4); clr_tally(); toggle_a(6);
        chk("R8", n_pulse, 3, "mode 5 strobes");
        chk("R8", n_up, 0, "mode 5 ups with B low");
        use_mode(6); pb = 1'b1; idle(4); clr_tally(); toggle_a(6);
        chk("R8", n_pulse, 6, "mode 6 strobes");

        // R9: gated internal tick
        pa = 1'b0; use_mode(7); tick_en = 1; idle(5); clr_tally(); idle(50);
        chk("R9", n_pulse, 0, "strobes with gate closed");
        pa = 1'b1; pb = 1'b1; idle(5); clr_tally(); idle(50);
        chk("R9", n_pulse, 10, "strobes with gate open");
        chk("R9", n_up, 10, "ups with B high");
        tick_en = 0; pa = 1'b0; pb = 1'b0; idle(5);

        // R10: mode switch lands on a pending edge
        use_mode(5); pa = 1'b1; idle(5); clr_tally();
        @(negedge clk); pa = 1'b0;
        @(negedge clk);
        @(negedge clk); mode = 3'd1;
        idle(6);
        chk("R10", n_pulse, 0, "strobes across mode switch");
        set_idx(0); idle(6);

        // R11: direction quiet without strobes over an idle stretch
        clr_tally(); pb = 1'b1; idle(10);
        chk("R11", n_up, 0, "ups while idle");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule